// File: doc/BRIEF.md
# Triggered Sample Pipeline and Event Framer

This block holds detector samples in digital storage and needs no analog capture. On every sample strobe, one row is written into a circular pipeline. A row holds one 12-bit sample for each channel of the group. When a level-1 accept (L1A) pulse arrives, the block records where the event's window begins: the current write position minus a programmable latency, counted in sample strobes. It stores that position with an event number in a small descriptor queue. An L1A is never refused because an earlier event is still being read out. A new event is lost only when the descriptor queue is full.

A framer drains the queue one event at a time. Each event goes out as one raw Ethernet MAC frame on a byte-wide valid/ready stream, with no IP layer. The frame holds the destination and source addresses, an EtherType, the 16-bit event number, the sample window and a CRC-32 check sequence. The sink can stall the stream at any byte. Nothing is lost while it does, as long as the pipeline is deep enough to cover the latency plus the readout backlog.

Top module: `l1a_event_framer`

## Requirements
- R1: After reset, tx_valid is low and evt_drops is zero.
- R2: The payload holds WIN rows, taken from the row at write position minus lat_cfg onwards. Here the write position is the number of sample strobes before the L1A edge. Rows are sent oldest first. Within a row, channels go in ascending order, and channel c is taken from smp_data[12c+11:12c]. Each sample takes two bytes, most significant byte first, with the upper four bits zero.
- R3: A frame is 148 bytes with the defaults. It starts with a 16-byte header: the destination MAC, then the source MAC, then the EtherType, then the event number. Each field is sent most significant byte first.
- R4: The last four bytes are the complement of the CRC-32 of all preceding bytes. The CRC uses the reflected polynomial 0xEDB88320 with an all-ones start value, and it is sent least significant byte first.
- R5: tx_sof is high only with the first byte of a frame and tx_eof only with the last byte. The two are never high together.
- R6: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data, tx_sof and tx_eof hold their values.
- R7: If the queue is empty and the framer is idle, an L1A sampled on clock edge E gives tx_valid high with tx_sof after edge E+1, and not before. The edge that completes a frame's last byte leaves tx_valid low for one cycle.
- R8: L1A pulses on consecutive clock cycles each yield a complete frame, in arrival order.
- R9: An L1A that arrives while the queue holds QD events is dropped, and evt_drops increases by one.
- R10: The event number starts at 0 after reset and increases on every L1A, dropped ones included. A dropped event therefore leaves a gap in the numbering.
- R11: The window start is fixed when the L1A is sampled. Changing lat_cfg later does not move an event that is already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe; writes one row |
| smp_data | input | NCH*SW (48) | One sample per channel, channel 0 in the low bits |
| l1a | input | 1 | Level-1 accept pulse |
| lat_cfg | input | AW (8) | Trigger latency in sample strobes |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| evt_drops | output | DROP_W (16) | Count of events dropped because the queue was full (wraps) |

## Verification
The first byte of a frame is due two edges after the L1A edge. The bench checks this from idle by looking at tx_valid at the falling edge after the L1A edge (still low) and at the one after that (high with tx_sof). Every other byte of a frame is timed only by the handshake. The monitor therefore captures a byte at a falling edge whenever valid and ready are both high, because the transfer completes on the next rising edge. It checks the whole frame once the 148th byte is captured. The drop counter is read after the last dropped L1A has passed its edge.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int HDR_BYTES = 16;
  localparam int FCS_BYTES = 4;

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PAY, TX_FCS} tx_st_e;

  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] x;
    x = c;
    for (int i = 0; i < 8; i++)
      x = (x >> 1) ^ (((x[0] ^ d[i]) != 1'b0) ? 32'hEDB88320 : 32'h0);
    return x;
  endfunction
endpackage

// File: rtl/sample_pipe.sv
module sample_pipe #(
  parameter int NCH   = 4,
  parameter int SW    = 12,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int RW   = NCH * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  output logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_addr,
  output logic [RW-1:0] rd_row
);
  logic [RW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_row;
  end

  assign rd_row = mem[rd_addr];
endmodule

// File: rtl/evt_queue.sv
module evt_queue #(
  parameter int AW     = 8,
  parameter int QD     = 4,
  parameter int EW     = 16,
  parameter int DROP_W = 16,
  localparam int QW    = (QD > 1) ? $clog2(QD) : 1,
  localparam int CW    = $clog2(QD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [AW-1:0]     push_start,
  input  logic              pop,
  output logic              empty,
  output logic [AW-1:0]     head_start,
  output logic [EW-1:0]     head_evn,
  output logic [DROP_W-1:0] drops
);
  logic [AW+EW-1:0] slots [QD];
  logic [QW-1:0]    wr_i, rd_i;
  logic [CW-1:0]    count;
  logic [EW-1:0]    evn;
  logic             full, accept;

  assign full   = (count == CW'(QD));
  assign empty  = (count == '0);
  assign accept = push && !full;
  assign {head_start, head_evn} = slots[rd_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_i  <= '0;
      rd_i  <= '0;
      count <= '0;
      evn   <= '0;
      drops <= '0;
    end else begin
      if (push) evn <= evn + 1'b1;
      if (push && full) drops <= drops + 1'b1;
      if (accept) wr_i <= (wr_i == QW'(QD - 1)) ? '0 : wr_i + 1'b1;
      if (pop) rd_i <= (rd_i == QW'(QD - 1)) ? '0 : rd_i + 1'b1;
      count <= count + CW'(accept) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) slots[wr_i] <= {push_start, evn};
  end

  // R9
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |=> drops == $past(drops) + 1'b1);

  // R9
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(QD));
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int          NCH   = 4,
  parameter int          SW    = 12,
  parameter int          WIN   = 16,
  parameter int          AW    = 8,
  parameter logic [47:0] DST   = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC   = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETYPE = 16'h88B5,
  localparam int RW  = NCH * SW,
  localparam int RCW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty,
  input  logic [AW-1:0] q_start,
  input  logic [15:0]   q_evn,
  output logic          q_pop,
  output logic [AW-1:0] rd_addr,
  input  logic [RW-1:0] rd_row,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_sof,
  output logic          tx_eof
);
  import efr_pkg::*;

  tx_st_e         st;
  logic [3:0]     idx;
  logic [RCW-1:0] row;
  logic [CHW-1:0] ch;
  logic           half;
  logic [AW-1:0]  base;
  logic [15:0]    evn_q;
  logic [31:0]    crc;
  logic [127:0]   hdr;
  logic [15:0]    wide;
  logic           fire;

  assign hdr      = {DST, SRC, ETYPE, evn_q};
  assign rd_addr  = base + AW'(row);
  assign wide     = 16'(rd_row[ch*SW +: SW]);
  assign tx_valid = (st != TX_IDLE);
  assign fire     = tx_valid && tx_ready;
  assign q_pop    = (st == TX_IDLE) && !q_empty;
  assign tx_sof   = (st == TX_HDR) && (idx == 4'd0);
  assign tx_eof   = (st == TX_FCS) && (idx == 4'd3);

  always_comb begin
    unique case (st)
      TX_HDR:  tx_data = hdr[8*(15 - idx) +: 8];
      TX_PAY:  tx_data = half ? wide[7:0] : wide[15:8];
      TX_FCS:  tx_data = ~crc[8*idx[1:0] +: 8];
      default: tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_IDLE; idx <= '0; row <= '0; ch <= '0; half <= 1'b0;
      base <= '0; evn_q <= '0; crc <= '1;
    end else begin
      unique case (st)
        TX_IDLE: if (q_pop) begin
          base <= q_start; evn_q <= q_evn; crc <= '1;
          idx <= '0; row <= '0; ch <= '0; half <= 1'b0;
          st <= TX_HDR;
        end
        TX_HDR: if (fire) begin
          crc <= crc32_step(crc, tx_data);
          if (idx == 4'(HDR_BYTES - 1)) begin idx <= '0; st <= TX_PAY; end
          else idx <= idx + 1'b1;
        end
        TX_PAY: if (fire) begin
          crc  <= crc32_step(crc, tx_data);
          half <= !half;
          if (half) begin
            if (ch == CHW'(NCH - 1)) begin
              ch <= '0;
              if (row == RCW'(WIN - 1)) begin idx <= '0; st <= TX_FCS; end
              else row <= row + 1'b1;
            end else ch <= ch + 1'b1;
          end
        end
        TX_FCS: if (fire) begin
          if (idx == 4'(FCS_BYTES - 1)) st <= TX_IDLE;
          else idx <= idx + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  // R5
  sof_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |-> tx_valid && !tx_eof);

  // R7
  eof_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof |=> !tx_valid);
endmodule

// File: rtl/l1a_event_framer.sv
module l1a_event_framer #(
  parameter int          NCH    = 4,
  parameter int          SW     = 12,
  parameter int          WIN    = 16,
  parameter int          DEPTH  = 256,
  parameter int          QD     = 4,
  parameter int          DROP_W = 16,
  parameter logic [47:0] DST    = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC    = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETYPE  = 16'h88B5,
  localparam int AW = $clog2(DEPTH),
  localparam int RW = NCH * SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [RW-1:0]     smp_data,
  input  logic              l1a,
  input  logic [AW-1:0]     lat_cfg,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic [DROP_W-1:0] evt_drops
);
  logic [AW-1:0] wr_ptr, rd_addr, head_start;
  logic [RW-1:0] rd_row;
  logic [15:0]   head_evn;
  logic          q_empty, q_pop;

  sample_pipe #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .wr_en(smp_en), .wr_row(smp_data),
    .wr_ptr(wr_ptr), .rd_addr(rd_addr), .rd_row(rd_row));

  evt_queue #(.AW(AW), .QD(QD), .EW(16), .DROP_W(DROP_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(l1a), .push_start(wr_ptr - lat_cfg),
    .pop(q_pop), .empty(q_empty), .head_start(head_start),
    .head_evn(head_evn), .drops(evt_drops));

  frame_tx #(.NCH(NCH), .SW(SW), .WIN(WIN), .AW(AW),
             .DST(DST), .SRC(SRC), .ETYPE(ETYPE)) u_tx (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_start(head_start),
    .q_evn(head_evn), .q_pop(q_pop), .rd_addr(rd_addr), .rd_row(rd_row),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sof(tx_sof), .tx_eof(tx_eof));
endmodule

// File: tb/tb_l1a_event_framer.sv
module tb_l1a_event_framer;
  localparam int CLK_P = 10;
  localparam int NCH = 4, WIN = 16, FLEN = 16 + WIN * NCH * 2 + 4;

  logic        clk = 0, rst_n = 0, smp_en = 0, l1a = 0, tx_ready = 0;
  logic [47:0] smp_data = '0;
  logic [7:0]  lat_cur = 8'd20;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_sof, tx_eof;
  logic [15:0] evt_drops;

  int n_chk = 0, n_fail = 0, nwr = 0, cyc = 0, rdy_mode = 0;
  int exp_start[256], exp_evn[256];
  int exp_n = 0, ev_next = 0, rx_n = 0, pos = 0, frm_err5 = 0, hold_err = 0;
  logic [7:0] rxbuf[FLEN];
  logic prev_v = 0, prev_r = 0, prev_sof = 0, prev_eof = 0;
  logic [7:0] prev_d = '0;

  always #(CLK_P/2) clk = ~clk;

  l1a_event_framer dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data), .l1a(l1a),
    .lat_cfg(lat_cur), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .evt_drops(evt_drops));

  function automatic logic [11:0] sval(int k, int c);
    return 12'((k * 157 + c * 691 + 23) ^ (k >> 3));
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic check_frame(int i);
    logic [7:0] e[FLEN];
    logic [31:0] c;
    logic [127:0] h;
    int b, bad_h, bad_p, bad_f;
    h = {48'h02_00_00_00_00_01, 48'h02_00_00_00_00_02, 16'h88B5, 16'(exp_evn[i])};
    for (int k = 0; k < 16; k++) e[k] = h[127 - 8*k -: 8];
    b = 16;
    for (int r = 0; r < WIN; r++)
      for (int ch = 0; ch < NCH; ch++) begin
        e[b]   = {4'h0, sval(exp_start[i] + r, ch)[11:8]};
        e[b+1] = sval(exp_start[i] + r, ch)[7:0];
        b += 2;
      end
    c = 32'hFFFFFFFF;
    for (int k = 0; k < FLEN - 4; k++)
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ e[k][j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    c = ~c;
    for (int k = 0; k < 4; k++) e[FLEN - 4 + k] = c[8*k +: 8];
    bad_h = -1; bad_p = -1; bad_f = -1;
    for (int k = FLEN - 1; k >= 0; k--)
      if (rxbuf[k] !== e[k]) begin
        if (k < 16) bad_h = k; else if (k < FLEN - 4) bad_p = k; else bad_f = k;
      end
    chk(bad_h < 0, "R3 header byte", (bad_h < 0) ? 0 : int'(rxbuf[bad_h]), (bad_h < 0) ? 0 : int'(e[bad_h]));
    chk(bad_p < 0, "R2 payload byte", (bad_p < 0) ? 0 : int'(rxbuf[bad_p]), (bad_p < 0) ? 0 : int'(e[bad_p]));
    chk(bad_f < 0, "R4 fcs byte", (bad_f < 0) ? 0 : int'(rxbuf[bad_f]), (bad_f < 0) ? 0 : int'(e[bad_f]));
    chk(frm_err5 == 0, "R5 sof/eof markers", frm_err5, 0);
    frm_err5 = 0;
  endtask

  always @(posedge clk) if (smp_en) nwr <= nwr + 1;

  always @(negedge clk) begin
    cyc++;
    smp_en = (cyc % 8 == 0);
    for (int ch = 0; ch < NCH; ch++) smp_data[12*ch +: 12] = sval(nwr, ch);
  end

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: tx_ready <= 1'b0;
      1: tx_ready <= 1'b1;
      default: tx_ready <= ($urandom % 10) < 7;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && !prev_r &&
          (!tx_valid || tx_data !== prev_d || tx_sof !== prev_sof || tx_eof !== prev_eof))
        hold_err++;
      if (tx_valid && tx_ready) begin
        if ((pos == 0) != (tx_sof === 1'b1)) frm_err5++;
        if ((pos == FLEN - 1) != (tx_eof === 1'b1)) frm_err5++;
        rxbuf[pos] = tx_data;
        if (pos == FLEN - 1) begin
          check_frame(rx_n);
          rx_n++;
          pos = 0;
        end else pos++;
      end
      prev_v = tx_valid; prev_r = tx_ready; prev_d = tx_data;
      prev_sof = tx_sof; prev_eof = tx_eof;
    end
  end

  task automatic fire_l1a(bit keep);
    l1a = 1'b1;
    if (keep) begin
      exp_start[exp_n] = nwr - int'(lat_cur);
      exp_evn[exp_n] = ev_next;
      exp_n++;
    end
    ev_next++;
    @(negedge clk);
    l1a = 1'b0;
  endtask

  task automatic wait_rx();
    while (rx_n < exp_n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int s0, ev_gap;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", int'(tx_valid), 0);
    chk(evt_drops == 16'd0, "R1 evt_drops after reset", int'(evt_drops), 0);
    while (nwr < 64) @(negedge clk);
    rdy_mode = 1;
    repeat (2) @(negedge clk);

    // R7: first byte timing from idle
    fire_l1a(1);
    chk(tx_valid == 1'b0, "R7 valid one edge after L1A", int'(tx_valid), 0);
    @(negedge clk);
    chk(tx_valid && tx_sof, "R7 valid+sof two edges after L1A", int'(tx_valid && tx_sof), 1);
    wait_rx();

    // R8: back-to-back accepts
    s0 = rx_n;
    fire_l1a(1);
    fire_l1a(1);
    wait_rx();
    chk(rx_n - s0 == 2, "R8 frames from consecutive L1As", rx_n - s0, 2);

    // R11: latency change after capture
    lat_cur = 8'd20;
    @(negedge clk);
    fire_l1a(1);
    s0 = exp_start[exp_n - 1];
    lat_cur = 8'd40;
    wait_rx();
    chk({rxbuf[16], rxbuf[17]} == 16'(sval(s0, 0)), "R11 window start kept",
        int'({rxbuf[16], rxbuf[17]}), int'(sval(s0, 0)));

    // R9 / R10: overflow with a stalled sink
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    fire_l1a(1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      fire_l1a(i < 4);
      @(negedge clk);
    end
    chk(evt_drops == 16'd2, "R9 drop counter", int'(evt_drops), 2);
    rdy_mode = 1;
    wait_rx();
    ev_gap = ev_next;
    fire_l1a(1);
    wait_rx();
    chk({rxbuf[14], rxbuf[15]} == 16'(ev_gap), "R10 event number after drops",
        int'({rxbuf[14], rxbuf[15]}), ev_gap);
    chk(evt_drops == 16'd2, "R9 drop counter steady", int'(evt_drops), 2);

    // random phase: random latency, random back-pressure (R2 R4 R6)
    rdy_mode = 2;
    for (int i = 0; i < 20; i++) begin
      lat_cur = 8'(16 + $urandom % 45);
      fire_l1a(1);
      if ($urandom % 4 == 0) fire_l1a(1);
      wait_rx();
      repeat ($urandom % 8) @(negedge clk);
    end
    chk(hold_err == 0, "R6 stall hold", hold_err, 0);
    chk(rx_n == exp_n, "R8 frame count", rx_n, exp_n);
    report();
  end
endmodule